// File: doc/BRIEF.md
# Two-Mode Serial Port with Shift-Register and Asynchronous Operation

This block is a full-duplex serial port with one control register, one data buffer address and two sticky completion flags. The control register selects the mode. In the synchronous shift mode the port drives the serial clock on `txd` and moves data on a single bidirectional data line, split here into `rxd_in`, `rxd_out` and an output enable. In the asynchronous mode `txd` and `rxd_in` carry standard start/stop framed bytes, and the bit timing comes from an external timer overflow strobe.

Writing the buffer address starts a transmission. In asynchronous mode, completed receptions go into a holding register. The next frame is assembled in a separate shift register, so a byte can arrive while the previous one is still unread. Software clears the completion flags by writing the control register.

In asynchronous mode, one bit lasts 16 receive-sample ticks. A tick is every second overflow strobe when the rate-double bit is 0, and every strobe when it is 1. The bit rate is therefore the overflow rate divided by 32 or by 16.

Top module: `serial_port_dm`

## Requirements
- R1: After reset, `ctl_q` is 0x00, `rx_byte` is 0x00, `txd` is 1 and `rxd_oe` is 0.
- R2: A write with `wr_sel`=0 loads the control register, and `ctl_q` reads it back. The fields are: [1:0] mode (00 = shift mode, 01 = asynchronous 8-bit), [2] receive enable, [3] rate double, [4] transmit-done flag, [5] receive-ready flag, [7:6] read as 0. In the same cycle, a hardware flag set wins over a software write.
- R3: In asynchronous mode, a write with `wr_sel`=1 sends one frame on `txd`: a start bit 0, eight data bits LSB first, then a stop bit 1. `txd` idles at 1.
- R4: An asynchronous bit lasts 32 overflow strobes with rate double 0 and 16 strobes with rate double 1. The span from the start edge to the transmit-done flag is therefore 10 bit times.
- R5: The transmit-done flag sets once, at the end of the stop bit, and is still 0 while the stop bit is being sent. A buffer write made while a transmission is in progress is ignored.
- R6: With receive enable 1 in asynchronous mode, a valid frame on `rxd_in` is stored in `rx_byte`, and the receive-ready flag sets by the middle of the stop bit.
- R7: A low pulse on `rxd_in` that has ended before the middle of the start bit starts no reception, and no flag is set.
- R8: A frame whose stop bit reads 0 is discarded. `rx_byte` and the receive-ready flag are left unchanged.
- R9: Reception is buffered. A frame that completes while the receive-ready flag is 0 is stored even if it began while the flag was 1. A frame that completes while the flag is 1 is lost, and `rx_byte` keeps its value.
- R10: Transmit and receive run at the same time in asynchronous mode without disturbing each other.
- R11: In shift mode, a buffer write sends eight bits LSB first on `rxd_out` with `rxd_oe`=1. `txd` is the shift clock: for each bit it is low for SHIFT_HALF cycles, then high for SHIFT_HALF cycles, and the data is valid at its rising edge. The transmit-done flag sets after the eighth bit.
- R12: In shift mode, reception starts when receive enable is 1 and the receive-ready flag is 0. The port clocks eight bits from `rxd_in` at the rising edges of `txd`, keeps `rxd_oe`=0, stores the byte in `rx_byte` and sets the receive-ready flag.
- R13: With receive enable 0 in asynchronous mode, traffic on `rxd_in` has no effect on `rx_byte` or on the receive-ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = data buffer |
| wr_data | input | DATA_W | Write data |
| ovf_tick | input | 1 | One-cycle timer overflow strobe |
| rxd_in | input | 1 | Serial receive line (shift mode: data in) |
| txd | output | 1 | Serial transmit line (shift mode: shift clock) |
| rxd_out | output | 1 | Shift-mode data out |
| rxd_oe | output | 1 | Shift-mode data output enable |
| ctl_q | output | 8 | Control register and flags |
| rx_byte | output | DATA_W | Received byte holding register |

## Verification
The hardest case to reach is the buffered reception of R9. The bench must have the receive-ready flag still set while the next frame's start bit arrives, then clear the flag before that frame's stop bit completes. To get there, a frame driver runs in parallel with a control-register write that is timed a few bit periods into the second frame. A third frame is then sent with the flag left set, and the bench confirms that this frame is dropped. The bench also times the stop bit of a rejected frame so that it cannot restart a false reception.

// File: rtl/serial_port_dm.sv
module serial_port_dm #(
  parameter int DATA_W     = 8,
  parameter int OVS        = 16,
  parameter int SHIFT_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ovf_tick,
  input  logic              rxd_in,
  output logic              txd,
  output logic              rxd_out,
  output logic              rxd_oe,
  output logic [7:0]        ctl_q,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int OW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W + 2);
  localparam int HW = $clog2(SHIFT_HALF + 1);
  localparam logic [OW-1:0] CNT_LAST = OW'(OVS - 1);
  localparam logic [OW-1:0] CNT_MID  = OW'(OVS / 2 - 1);
  localparam logic [BW-1:0] BIT_STOP = BW'(DATA_W + 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);
  localparam logic [HW-1:0] DIV_LAST = HW'(SHIFT_HALF - 1);

  logic [1:0] mode_q;
  logic       ren_q, dbl_q, ti_q, ri_q;
  logic       pre_q;
  logic [1:0] rs_q;

  wire ctl_wr    = wr_en & ~wr_sel;
  wire buf_wr    = wr_en & wr_sel;
  wire sync_mode = (mode_q == 2'b00);
  wire tick      = ovf_tick & (dbl_q | pre_q);
  wire rx_s      = rs_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_q <= 1'b0;
      rs_q  <= 2'b11;
    end else begin
      if (ovf_tick) pre_q <= ~pre_q;
      rs_q <= {rs_q[0], rxd_in};
    end

  // asynchronous transmitter
  logic              atx_busy;
  logic [DATA_W+1:0] atx_sr;
  logic [BW-1:0]     atx_bit;
  logic [OW-1:0]     atx_cnt;
  wire atx_fin = atx_busy & tick & (atx_cnt == CNT_LAST) & (atx_bit == BIT_STOP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      atx_busy <= 1'b0;
      atx_sr   <= '1;
      atx_bit  <= '0;
      atx_cnt  <= '0;
    end else if (!atx_busy) begin
      if (buf_wr && !sync_mode) begin
        atx_busy <= 1'b1;
        atx_sr   <= {1'b1, wr_data, 1'b0};
        atx_bit  <= '0;
        atx_cnt  <= '0;
      end
    end else if (tick) begin
      if (atx_cnt == CNT_LAST) begin
        atx_cnt <= '0;
        if (atx_bit == BIT_STOP) atx_busy <= 1'b0;
        else begin
          atx_bit <= atx_bit + 1'b1;
          atx_sr  <= {1'b1, atx_sr[DATA_W+1:1]};
        end
      end else atx_cnt <= atx_cnt + 1'b1;
    end

  // asynchronous receiver
  logic              arx_busy;
  logic [OW-1:0]     arx_cnt;
  logic [BW-1:0]     arx_bit;
  logic [DATA_W-1:0] arx_sr;
  wire arx_mid = arx_busy & tick & (arx_cnt == CNT_MID);
  wire arx_fin = arx_mid & (arx_bit == BIT_STOP) & rx_s & ~ri_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arx_busy <= 1'b0;
      arx_cnt  <= '0;
      arx_bit  <= '0;
      arx_sr   <= '0;
    end else if (!arx_busy) begin
      if (!sync_mode && ren_q && tick && !rx_s) begin
        arx_busy <= 1'b1;
        arx_cnt  <= '0;
        arx_bit  <= '0;
      end
    end else if (tick) begin
      if (arx_cnt == CNT_LAST) begin
        arx_cnt <= '0;
        arx_bit <= arx_bit + 1'b1;
      end else arx_cnt <= arx_cnt + 1'b1;
      if (arx_cnt == CNT_MID) begin
        if (arx_bit == '0) begin
          if (rx_s) arx_busy <= 1'b0;
        end else if (arx_bit == BIT_STOP) arx_busy <= 1'b0;
        else arx_sr <= {rx_s, arx_sr[DATA_W-1:1]};
      end
    end

  // shift-register engine
  logic              sh_busy, sh_rx, sh_ph;
  logic [DATA_W-1:0] sh_sr;
  logic [BW-1:0]     sh_bit;
  logic [HW-1:0]     sh_div;
  wire sh_edge  = sh_busy & (sh_div == DIV_LAST);
  wire sh_fin   = sh_edge & sh_ph & (sh_bit == BIT_LAST);
  wire sh_go_tx = sync_mode & ~sh_busy & buf_wr;
  wire sh_go_rx = sync_mode & ~sh_busy & ~wr_en & ren_q & ~ri_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_busy <= 1'b0;
      sh_rx   <= 1'b0;
      sh_ph   <= 1'b0;
      sh_sr   <= '0;
      sh_bit  <= '0;
      sh_div  <= '0;
    end else if (sh_go_tx || sh_go_rx) begin
      sh_busy <= 1'b1;
      sh_rx   <= sh_go_rx;
      sh_sr   <= sh_go_tx ? wr_data : '0;
      sh_bit  <= '0;
      sh_ph   <= 1'b0;
      sh_div  <= '0;
    end else if (sh_busy) begin
      sh_div <= sh_edge ? '0 : sh_div + 1'b1;
      if (sh_edge) begin
        sh_ph <= ~sh_ph;
        if (!sh_ph && sh_rx) sh_sr <= {rxd_in, sh_sr[DATA_W-1:1]};
        if (sh_ph) begin
          if (sh_bit == BIT_LAST) sh_busy <= 1'b0;
          else begin
            sh_bit <= sh_bit + 1'b1;
            if (!sh_rx) sh_sr <= sh_sr >> 1;
          end
        end
      end
    end

  // control register, flags and holding register
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {ri_q, ti_q, dbl_q, ren_q, mode_q} <= '0;
      rx_byte <= '0;
    end else begin
      if (ctl_wr) {ri_q, ti_q, dbl_q, ren_q, mode_q} <= wr_data[5:0];
      if (atx_fin || (sh_fin && !sh_rx)) ti_q <= 1'b1;
      if (arx_fin || (sh_fin && sh_rx)) ri_q <= 1'b1;
      if (arx_fin) rx_byte <= arx_sr;
      else if (sh_fin && sh_rx) rx_byte <= sh_sr;
    end

  assign txd     = sync_mode ? (~sh_busy | sh_ph) : (~atx_busy | atx_sr[0]);
  assign rxd_out = sh_sr[0];
  assign rxd_oe  = sync_mode & sh_busy & ~sh_rx;
  assign ctl_q   = {2'b00, ri_q, ti_q, dbl_q, ren_q, mode_q};
endmodule

module serial_port_dm_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              txd,
  input logic              rxd_oe,
  input logic [7:0]        ctl_q,
  input logic [DATA_W-1:0] rx_byte,
  input logic              atx_busy,
  input logic              sh_busy,
  input logic              sh_rx
);
  assert_txd_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[1:0] != 2'b00 && !atx_busy) |-> txd);

  assert_ti_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[4]) |-> ($past(wr_en && !wr_sel && wr_data[4]) || $past(atx_busy) || $past(sh_busy)));

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> $rose(ctl_q[5]));

  assert_oe_from_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxd_oe) |-> $past(wr_en && wr_sel));

  assert_shift_rx_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sh_busy) && sh_rx) |-> $past(ctl_q[2] && !ctl_q[5] && ctl_q[1:0] == 2'b00));
endmodule

bind serial_port_dm serial_port_dm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .txd(txd), .rxd_oe(rxd_oe), .ctl_q(ctl_q), .rx_byte(rx_byte),
  .atx_busy(atx_busy), .sh_busy(sh_busy), .sh_rx(sh_rx)
);

// File: tb/serial_port_dm_test.sv
module serial_port_dm_test;
  localparam int OVF_PER = 3;
  localparam int OVS     = 16;
  localparam int HALF    = 4;
  localparam logic [7:0] M_SH = 8'h00, M_AS = 8'h01, REN = 8'h04, DBL = 8'h08;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_sel = 0, ovf = 0, rxd_in = 1;
  logic [7:0] wr_data = 0;
  logic txd, rxd_out, rxd_oe;
  logic [7:0] ctl_q, rx_byte;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  serial_port_dm #(.DATA_W(8), .OVS(OVS), .SHIFT_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ovf_tick(ovf), .rxd_in(rxd_in), .txd(txd), .rxd_out(rxd_out), .rxd_oe(rxd_oe),
    .ctl_q(ctl_q), .rx_byte(rx_byte));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k = (k + 1) % OVF_PER;
      ovf = (k == 0);
    end
  end

  function automatic int bitc(bit dbl);
    return OVS * OVF_PER * (dbl ? 1 : 2);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(bit sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send_frame(logic [7:0] b, int bc, bit stopv, int stop_len);
    logic [8:0] f;
    f = {b, 1'b0};
    @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      rxd_in = f[i];
      repeat (bc) @(negedge clk);
    end
    rxd_in = stopv;
    repeat (stop_len) @(negedge clk);
    rxd_in = 1;
  endtask

  task automatic cap_tx(int bc, output logic [7:0] got, output bit fr_ok, output int len);
    int t, t0;
    t = 0;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    t0 = cyc;
    repeat (bc / 2) @(negedge clk);
    fr_ok = (txd == 1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (bc) @(negedge clk);
      got[i] = txd;
    end
    repeat (bc) @(negedge clk);
    fr_ok = fr_ok && (txd == 1'b1) && (ctl_q[4] == 1'b0);
    t = 0;
    while (!ctl_q[4] && t < 5000) begin @(negedge clk); t++; end
    len = cyc - t0;
  endtask

  task automatic async_tx_test(logic [7:0] b, bit dbl);
    logic [7:0] got; bit fr_ok; int len, tp;
    tp = OVF_PER * (dbl ? 1 : 2);
    write_reg(0, M_AS | (dbl ? DBL : 8'h00));
    write_reg(1, b);
    cap_tx(bitc(dbl), got, fr_ok, len);
    check(got == b, "R3 tx data", got, b);
    check(fr_ok, "R5 start/stop and flag timing", fr_ok, 1);
    check(len >= 159 * tp && len <= 160 * tp + 1, "R4 frame length", len, 160 * tp);
  endtask

  task automatic async_rx(logic [7:0] b, bit dbl);
    send_frame(b, bitc(dbl), 1'b1, bitc(dbl));
    repeat (2) @(negedge clk);
  endtask

  task automatic shift_tx_test(logic [7:0] b);
    logic [7:0] got; bit oe_ok; int low_len, t;
    oe_ok = 1; low_len = 0;
    write_reg(0, M_SH);
    write_reg(1, b);
    for (int i = 0; i < 8; i++) begin
      t = 0;
      while (txd !== 1'b0 && t < 100) begin @(negedge clk); t++; end
      t = 0;
      while (txd !== 1'b1 && t < 100) begin @(negedge clk); t++; end
      if (i == 0) low_len = t;
      got[i] = rxd_out;
      oe_ok = oe_ok && (rxd_oe == 1'b1);
    end
    repeat (2 * HALF) @(negedge clk);
    check(got == b, "R11 shift tx data", got, b);
    check(oe_ok, "R11 shift tx output enable", oe_ok, 1);
    check(low_len == HALF, "R11 shift clock low phase", low_len, HALF);
    check(ctl_q[4] == 1'b1, "R11 shift tx done flag", ctl_q[4], 1);
  endtask

  task automatic shift_rx_test(logic [7:0] b);
    bit oe_ok; int t;
    oe_ok = 1;
    write_reg(0, M_SH | REN);
    for (int i = 0; i < 8; i++) begin
      t = 0;
      while (txd !== 1'b0 && t < 100) begin @(negedge clk); t++; end
      rxd_in = b[i];
      t = 0;
      while (txd !== 1'b1 && t < 100) begin
        oe_ok = oe_ok && !rxd_oe;
        @(negedge clk); t++;
      end
    end
    repeat (2 * HALF) @(negedge clk);
    rxd_in = 1;
    check(rx_byte == b, "R12 shift rx data", rx_byte, b);
    check(ctl_q[5] == 1'b1, "R12 shift rx flag", ctl_q[5], 1);
    check(oe_ok, "R12 no drive during rx", oe_ok, 1);
    write_reg(0, M_SH);
  endtask

  initial begin
    int w = 0;
    while (!done && w < 150000) begin @(posedge clk); w++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, b, keep; bit fr_ok; int len;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    check(ctl_q == 8'h00 && rx_byte == 8'h00, "R1 reset regs", {ctl_q, rx_byte}, 0);
    check(txd == 1'b1 && rxd_oe == 1'b0, "R1 reset pins", {txd, rxd_oe}, 2);
    rst_n = 1;
    repeat (2) @(negedge clk);

    write_reg(0, 8'h2D);
    check(ctl_q == 8'h2D, "R2 control readback", ctl_q, 8'h2D);
    write_reg(0, 8'h05);
    check(ctl_q == 8'h05, "R2 flags cleared by write", ctl_q, 8'h05);

    async_tx_test(8'hA5, 1'b1);
    async_tx_test(8'h3C, 1'b0);
    async_tx_test(8'h01, 1'b1);

    write_reg(0, M_AS | DBL);
    write_reg(1, 8'h96);
    fork
      cap_tx(bitc(1), got, fr_ok, len);
      begin repeat (100) @(negedge clk); write_reg(1, 8'h5A); end
    join
    check(got == 8'h96, "R5 write while busy ignored", got, 8'h96);
    repeat (bitc(1)) @(negedge clk);
    check(txd == 1'b1, "R5 no second frame", txd, 1);

    write_reg(0, M_AS | DBL | REN);
    async_rx(8'hC3, 1);
    check(rx_byte == 8'hC3, "R6 rx byte", rx_byte, 8'hC3);
    check(ctl_q[5] == 1'b1, "R6 rx flag", ctl_q[5], 1);

    write_reg(0, M_AS | REN);
    async_rx(8'h4E, 0);
    check(rx_byte == 8'h4E, "R6 rx byte slow rate", rx_byte, 8'h4E);

    write_reg(0, M_AS | DBL | REN);
    @(negedge clk); rxd_in = 0;
    repeat (3 * OVF_PER) @(negedge clk); rxd_in = 1;
    repeat (200 * OVF_PER) @(negedge clk);
    check(ctl_q[5] == 1'b0, "R7 glitch rejected", ctl_q[5], 0);

    write_reg(0, M_AS | REN);
    send_frame(8'h77, bitc(0), 1'b0, 60);
    repeat (2 * bitc(0)) @(negedge clk);
    check(ctl_q[5] == 1'b0 && rx_byte == 8'h4E, "R8 bad stop discarded", {ctl_q[5], rx_byte}, 8'h4E);

    write_reg(0, M_AS | DBL | REN);
    async_rx(8'h11, 1);
    fork
      async_rx(8'h22, 1);
      begin repeat (3 * bitc(1)) @(negedge clk); write_reg(0, M_AS | DBL | REN); end
    join
    check(rx_byte == 8'h22 && ctl_q[5], "R9 second byte buffered", rx_byte, 8'h22);
    async_rx(8'h33, 1);
    check(rx_byte == 8'h22, "R9 overrun byte lost", rx_byte, 8'h22);

    write_reg(0, M_AS | DBL);
    async_rx(8'hE7, 1);
    check(rx_byte == 8'h22 && ctl_q[5] == 1'b0, "R13 disabled rx ignored", rx_byte, 8'h22);

    for (int n = 0; n < 8; n++) begin
      bit dbl;
      b = 8'($urandom);
      keep = 8'($urandom);
      dbl = 1'($urandom);
      write_reg(0, M_AS | REN | (dbl ? DBL : 8'h00));
      fork
        async_rx(keep, dbl);
        begin write_reg(1, b); cap_tx(bitc(dbl), got, fr_ok, len); end
      join
      check(got == b && fr_ok, "R10 duplex tx", got, b);
      check(rx_byte == keep, "R10 duplex rx", rx_byte, keep);
    end

    shift_tx_test(8'hB4);
    shift_tx_test(8'hFF);
    for (int n = 0; n < 4; n++) shift_tx_test(8'($urandom));
    shift_rx_test(8'h6D);
    shift_rx_test(8'h00);
    for (int n = 0; n < 4; n++) shift_rx_test(8'($urandom));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule